// File: doc/BRIEF.md
# Per-Block Flash Write-Protect Lock Controller

This block holds a write-protection state for every erase block of a flash array and changes those states in response to four range commands: unlock a range, unlock every block, lock a range, and lock-tight a range. Software loads a first-block and a last-block register, then strobes a command code. The controller walks the range one block per clock, rewriting block states and a write-protection status register as it goes. At the end it raises a one-cycle completion pulse, with an error flag when the walk ran off the end of the array.

A combinational query port returns the current state of any block, so the program and erase engines next to this block can tell whether a target block may be modified. The block does not program or erase the array. Its outputs are the protection states and the completion and error strobes.

Top module: `wp_lock_ctrl`

## Requirements
- R1: After a synchronous active-low reset every block reads locked, `wp_status` reads 3'b010, `busy`, `done` and `cmd_err` are low and both address registers are zero. State encodings are one-hot: lock-tight 3'b001, locked 3'b010, unlocked 3'b100, and every block always holds exactly one of them.
- R2: A `start_wr` strobe stores the low ADDR_W bits of `addr_wdata` (ADDR_W = clog2(NUM_BLOCKS)) into the first-block register and the same value into the last-block register. An `end_wr` strobe changes only the last-block register.
- R3: Code 0x23 sets every block from the first to the last index inclusive to unlocked, and `wp_status` takes the state most recently written to a block.
- R4: Code 0x2A does the same walk, setting blocks to locked.
- R5: An unlock or lock walk that reaches a lock-tight block stops there without error. That block and every block after it stay unchanged.
- R6: Code 0x2C walks the same range, leaves unlocked blocks untouched, and sets all other blocks to lock-tight, with `wp_status` set to lock-tight on each block it writes.
- R7: A lock-tight block keeps that state until reset, whatever commands follow.
- R8: A walk whose index reaches NUM_BLOCKS or above ends with `cmd_err` high during the `done` pulse. Blocks visited before that point keep their new states.
- R9: Code 0x27 walks from block 0 to block NUM_BLOCKS-1 with the unlock rule, including its stop at a lock-tight block.
- R10: `busy` is high for the whole walk. `cmd_valid` is ignored while `busy` is high. `done` is a one-cycle pulse in the cycle `busy` falls. A first index above the last index completes with no block changed and no error.
- R11: A `cmd_valid` strobe that carries any other code is ignored: no `busy`, no `done`, and no state changes.
- R12: `query_state` returns the state of block `query_blk`. For an index at or above NUM_BLOCKS it returns 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_wr | input | 1 | Write strobe for the first-block register (also loads the last-block register) |
| end_wr | input | 1 | Write strobe for the last-block register |
| addr_wdata | input | DATA_W | Write data for both address registers |
| start_addr | output | ADDR_W | Current first-block register |
| end_addr | output | ADDR_W | Current last-block register |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Walk ran past the last block; valid with done |
| wp_status | output | 3 | Last state written to any block |
| query_blk | input | ADDR_W | Block index to look up |
| query_state | output | 3 | State of the queried block |

## Verification
The hardest situation to set up is a walk that meets each of its early-exit conditions partway through a range. That requires a mix of unlocked, locked and lock-tight blocks already in the array, and those can only be built with earlier commands. The stimulus runs a chain of commands that build on each other. A full unlock comes first. A range lock and then a lock-tight that straddles the unlocked blocks leave a lock-tight island in the array, and later unlock, unlock-all and lock walks stop against it. With the default of twelve blocks and four-bit addresses, indices 12 to 15 can be written, which makes walks that end in the out-of-range error reachable. A command strobe is also issued while a walk is in progress, and a scoreboard confirms that it produces no second completion.

// File: rtl/wpl_pkg.sv
// Shared encodings for the write-protect lock controller.
// Assumes one-hot block states; neighbours decode the bit positions.
package wpl_pkg;
    typedef logic [2:0] lock_t;

    localparam lock_t LK_NONE   = 3'b000;
    localparam lock_t LK_TIGHT  = 3'b001;
    localparam lock_t LK_LOCKED = 3'b010;
    localparam lock_t LK_OPEN   = 3'b100;

    localparam logic [7:0] OP_UNLOCK     = 8'h23;
    localparam logic [7:0] OP_UNLOCK_ALL = 8'h27;
    localparam logic [7:0] OP_LOCK       = 8'h2A;
    localparam logic [7:0] OP_TIGHT      = 8'h2C;

    typedef enum logic [1:0] {
        W_OPEN  = 2'd0,
        W_LOCK  = 2'd1,
        W_TIGHT = 2'd2
    } walk_kind_e;
endpackage

// File: rtl/wpl_addr_regs.sv
// First/last block address registers.
// A first-block write also copies its value into the last-block register;
// only the low ADDR_W bits of the write data are kept.
module wpl_addr_regs #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              end_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q
);
    logic [ADDR_W-1:0] wval;
    logic              unused_hi;

    assign wval      = wdata[ADDR_W-1:0];
    assign unused_hi = ^wdata[DATA_W-1:ADDR_W];

    // Register update; an end write in the same cycle overrides the copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else begin
            if (start_wr) begin
                start_q <= wval;
                end_q   <= wval;
            end
            if (end_wr) begin
                end_q <= wval;
            end
        end
    end

    p_end_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !end_wr) |=> (end_q == start_q));

    p_start_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (end_wr && !start_wr) |=> $stable(start_q));
endmodule

// File: rtl/wpl_state_array.sv
// Per-block lock state storage, one one-hot register per erase block.
// Assumes a single writer (the walker) and returns 3'b000 for indices
// outside the array on both read ports.
module wpl_state_array
    import wpl_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int ADDR_W     = 4,
    parameter int IDX_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  lock_t             wr_state,
    input  logic [IDX_W-1:0]  rd_idx,
    output lock_t             rd_state,
    input  logic [ADDR_W-1:0] query_blk,
    output lock_t             query_state
);
    lock_t st [NUM_BLOCKS];

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        // One block's state: locked at reset, rewritten by the walker.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st[i] <= LK_LOCKED;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                st[i] <= wr_state;
            end
        end

        p_state_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(st[i]) == 1);

        p_tight_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] == LK_TIGHT) |=> (st[i] == LK_TIGHT));
    end

    // Walker read port mux.
    always_comb begin
        rd_state = LK_NONE;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_state = st[i];
        end
    end

    // Query port mux.
    always_comb begin
        query_state = LK_NONE;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (query_blk == ADDR_W'(i)) query_state = st[i];
        end
    end
endmodule

// File: rtl/wpl_walker.sv
// Command decoder and range walker.
// Visits one block per clock from the latched first index to the latched
// last index, applying the rule of the accepted command, and ends with a
// one-cycle done pulse. Assumes the state array answers rd_idx in the
// same cycle.
module wpl_walker
    import wpl_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int ADDR_W     = 4,
    parameter int IDX_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  lock_t             cur_state,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output lock_t             wr_state,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output lock_t             wp_status
);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_BLOCKS - 1);
    localparam logic [IDX_W-1:0] LIMIT_IDX = IDX_W'(NUM_BLOCKS);

    logic             busy_q, done_q, err_q;
    logic [IDX_W-1:0] idx_q, hi_q;
    walk_kind_e       kind_q, kind_d;
    lock_t            wp_q;
    logic             code_ok, all_d;
    logic             past_end, out_range, blocked, skip, finish;
    lock_t            target;

    // Decode the command code into a walk kind.
    always_comb begin
        code_ok = 1'b1;
        all_d   = 1'b0;
        kind_d  = W_OPEN;
        case (cmd_code)
            OP_UNLOCK:     kind_d = W_OPEN;
            OP_UNLOCK_ALL: all_d  = 1'b1;
            OP_LOCK:       kind_d = W_LOCK;
            OP_TIGHT:      kind_d = W_TIGHT;
            default:       code_ok = 1'b0;
        endcase
    end

    // Per-step decision for the block under the walk index.
    always_comb begin
        past_end  = idx_q > hi_q;
        out_range = idx_q >= LIMIT_IDX;
        blocked   = (kind_q != W_TIGHT) && (cur_state == LK_TIGHT);
        skip      = (kind_q == W_TIGHT) && (cur_state == LK_OPEN);
        case (kind_q)
            W_LOCK:  target = LK_LOCKED;
            W_TIGHT: target = LK_TIGHT;
            default: target = LK_OPEN;
        endcase
        finish = past_end || out_range || blocked;
        wr_en  = busy_q && !finish && !skip;
    end

    // Walk sequencing, completion strobes and status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            idx_q  <= '0;
            hi_q   <= '0;
            kind_q <= W_OPEN;
            wp_q   <= LK_LOCKED;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (!busy_q) begin
                if (cmd_valid && code_ok) begin
                    busy_q <= 1'b1;
                    kind_q <= kind_d;
                    idx_q  <= all_d ? '0 : {1'b0, start_addr};
                    hi_q   <= all_d ? LAST_IDX : {1'b0, end_addr};
                end
            end else if (finish) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                err_q  <= !past_end && out_range;
            end else begin
                idx_q <= idx_q + 1'b1;
                if (wr_en) wp_q <= target;
            end
        end
    end

    assign rd_idx    = idx_q;
    assign wr_state  = target;
    assign busy      = busy_q;
    assign done      = done_q;
    assign cmd_err   = err_q;
    assign wp_status = wp_q;

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> done);

    p_wp_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wp_status) == 1);

    p_bad_code_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !code_ok) |=> !busy);
endmodule

// File: rtl/wp_lock_ctrl.sv
// Top of the per-block write-protect lock controller.
// Ties the address registers, the range walker and the state array.
// Assumes NUM_BLOCKS >= 2; indices are clog2(NUM_BLOCKS) bits wide, so
// a non-power-of-two count leaves writable indices beyond the array.
module wp_lock_ctrl
    import wpl_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int DATA_W     = 16,
    localparam int ADDR_W    = $clog2(NUM_BLOCKS),
    localparam int IDX_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              end_wr,
    input  logic [DATA_W-1:0] addr_wdata,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] end_addr,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic [2:0]        wp_status,
    input  logic [ADDR_W-1:0] query_blk,
    output logic [2:0]        query_state
);
    logic [IDX_W-1:0] walk_idx;
    logic             walk_wr;
    lock_t            walk_state, blk_state;

    wpl_addr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .end_wr   (end_wr),
        .wdata    (addr_wdata),
        .start_q  (start_addr),
        .end_q    (end_addr)
    );

    wpl_walker #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .cur_state  (blk_state),
        .rd_idx     (walk_idx),
        .wr_en      (walk_wr),
        .wr_state   (walk_state),
        .busy       (busy),
        .done       (done),
        .cmd_err    (cmd_err),
        .wp_status  (wp_status)
    );

    wpl_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (walk_wr),
        .wr_idx      (walk_idx),
        .wr_state    (walk_state),
        .rd_idx      (walk_idx),
        .rd_state    (blk_state),
        .query_blk   (query_blk),
        .query_state (query_state)
    );
endmodule

// File: tb/wp_lock_ctrl_test.sv
// Scoreboard bench: the driver predicts each command's outcome and
// queues it; a monitor compares at every done pulse.
module wp_lock_ctrl_test;
    localparam int N = 12;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_wr = 1'b0, end_wr = 1'b0, cmd_valid = 1'b0;
    logic [15:0] addr_wdata = '0;
    logic [7:0] cmd_code = '0;
    logic [AW-1:0] query_blk = '0;
    logic [AW-1:0] start_addr, end_addr;
    logic busy, done, cmd_err;
    logic [2:0] wp_status, query_state;

    int checks = 0, errors = 0;

    typedef struct { bit err; logic [2:0] wp; } exp_t;
    exp_t sb[$];

    logic [2:0] m [N];
    logic [2:0] mwp;
    int ms, me;

    always #2.5 clk = ~clk;

    wp_lock_ctrl #(.NUM_BLOCKS(N), .DATA_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
        .addr_wdata(addr_wdata), .start_addr(start_addr), .end_addr(end_addr),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .busy(busy), .done(done),
        .cmd_err(cmd_err), .wp_status(wp_status), .query_blk(query_blk),
        .query_state(query_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every completion against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cmd_err == e.err, "R8 cmd_err at done", int'(cmd_err), int'(e.err));
                chk(wp_status == e.wp, "R3 wp_status at done", int'(wp_status), int'(e.wp));
            end
        end
    end

    task automatic wr_start(input int v);
        @(negedge clk); start_wr = 1'b1; addr_wdata = 16'(v);
        @(negedge clk); start_wr = 1'b0;
        ms = v & 15; me = ms;
    endtask

    task automatic wr_end(input int v);
        @(negedge clk); end_wr = 1'b1; addr_wdata = 16'(v);
        @(negedge clk); end_wr = 1'b0;
        me = v & 15;
    endtask

    // Reference walk built from the requirements.
    task automatic predict(input logic [7:0] code);
        int lo, hi;
        exp_t e;
        e.err = 1'b0;
        lo = (code == 8'h27) ? 0 : ms;
        hi = (code == 8'h27) ? N - 1 : me;
        for (int b = lo; b <= hi; b++) begin
            if (b >= N) begin e.err = 1'b1; break; end
            if (code == 8'h2C) begin
                if (m[b] == 3'b100) continue;
                m[b] = 3'b001; mwp = 3'b001;
            end else begin
                if (m[b] == 3'b001) break;
                m[b] = (code == 8'h2A) ? 3'b010 : 3'b100;
                mwp = m[b];
            end
        end
        e.wp = mwp;
        sb.push_back(e);
    endtask

    task automatic issue(input logic [7:0] code);
        predict(code);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk); cmd_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic check_blocks(input string req);
        for (int b = 0; b < N; b++) begin
            query_blk = AW'(b);
            #0.5;
            chk(query_state == m[b], req, int'(query_state), int'(m[b]));
        end
    endtask

    initial begin
        #1000000;
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < N; b++) m[b] = 3'b010;
        mwp = 3'b010; ms = 0; me = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wp_status == 3'b010, "R1 wp_status", int'(wp_status), 2);
        chk(!busy && !done && !cmd_err, "R1 strobes low", int'({busy, done, cmd_err}), 0);
        chk(start_addr == 0 && end_addr == 0, "R1 addresses", int'({start_addr, end_addr}), 0);
        check_blocks("R1 block locked after reset");

        // R2 masking and copy
        wr_start(16'h01F3);
        chk(start_addr == 3, "R2 start masked", int'(start_addr), 3);
        chk(end_addr == 3, "R2 end copied", int'(end_addr), 3);
        wr_end(7);
        chk(end_addr == 7, "R2 end written", int'(end_addr), 7);
        chk(start_addr == 3, "R2 start kept", int'(start_addr), 3);

        // R9 full unlock-all with an ignored strobe during the walk (R10)
        predict(8'h27);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h27;
        @(negedge clk); cmd_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy during walk", int'(busy), 1);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h2A;
        @(negedge clk); cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (20) @(negedge clk);
        check_blocks("R9 R10 unlock-all, busy strobe ignored");

        // R4 lock range 4..9
        wr_start(4); wr_end(9);
        issue(8'h2A);
        check_blocks("R4 lock range");

        // R6 lock-tight 2..8: 2,3 unlocked skipped
        wr_start(2); wr_end(8);
        issue(8'h2C);
        check_blocks("R6 lock-tight skips unlocked");

        // R5 unlock 0..11 stops at block 4
        wr_start(0); wr_end(11);
        issue(8'h23);
        check_blocks("R5 walk stops at lock-tight");

        // R3 unlock range without obstacle
        wr_start(9); wr_end(10);
        issue(8'h23);
        check_blocks("R3 unlock range");

        // R7 unlock-all against tight blocks
        issue(8'h27);
        check_blocks("R7 R9 tight blocks unchanged");

        // R4 relock 9..11
        wr_start(9); wr_end(11);
        issue(8'h2A);
        check_blocks("R4 relock");

        // R8 walk runs past the array
        wr_start(10); wr_end(15);
        issue(8'h23);
        check_blocks("R8 partial walk then error");
        wr_start(14);
        issue(8'h2A);
        check_blocks("R8 immediate error, no change");

        // R10 first index above last: empty walk
        wr_start(11); wr_end(2);
        issue(8'h2A);
        check_blocks("R10 empty range no change");

        // R11 unknown code
        begin
            bit saw_busy;
            saw_busy = 1'b0;
            @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h55;
            @(negedge clk); cmd_valid = 1'b0;
            for (int k = 0; k < 10; k++) begin
                if (busy) saw_busy = 1'b1;
                @(negedge clk);
            end
            chk(!saw_busy, "R11 no busy on unknown code", int'(saw_busy), 0);
            chk(wp_status == mwp, "R11 wp_status unchanged", int'(wp_status), int'(mwp));
            check_blocks("R11 states unchanged");
        end

        // R12 out-of-range query
        for (int b = N; b < 16; b++) begin
            query_blk = AW'(b);
            #0.5;
            chk(query_state == 3'b000, "R12 out-of-range query", int'(query_state), 0);
        end

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R10 every command completed", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule